// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block is the command engine of a flash-style byte memory built on an internal synchronous RAM. The host writes address/data pairs one clock at a time. The block recognises unlock-guarded command sequences within that stream and acts on three of them:

- byte program, which only clears bits;
- erase of one sector;
- erase of the whole array.

A fourth sequence sets a lock on the lowest block of the array. That lock holds until power-on reset.

Each operation keeps a busy flag high for a fixed number of clock cycles. While the flag is high, reads return a polling byte instead of array contents, and command writes are ignored. A halt input stops any running operation and silences the read data. An override input lets the host program and sector-erase the locked block.

The array is split into five sectors, each a fixed fraction of 2^ADDR_W bytes:

| Sector | Size | Default addresses (ADDR_W = 11) |
|---|---|---|
| boot | one eighth | 0x000 to 0x0FF |
| param A | one sixteenth | 0x100 to 0x17F |
| param B | one sixteenth | 0x180 to 0x1FF |
| main A | one quarter | 0x200 to 0x3FF |
| main B | one half | 0x400 to 0x7FF |

Top module: `fcc_flash_ctrl`

## Requirements
- R1: After `rst`, `busy` is 0 and the boot lock is clear.
- R2: When idle, `rd_data` presents the byte at `rd_addr` one clock after the address is sampled.
- R3: Byte program is four writes: (UNLOCK_A1, 0xAA), (UNLOCK_A2, 0x55), (UNLOCK_A1, 0xA0), then (target, value). The stored byte becomes old AND value. Defaults are UNLOCK_A1 = 0x555 and UNLOCK_A2 = 0x2AA.
- R4: A program holds `busy` high for exactly PROG_CYCLES clocks, starting the cycle after its last write. During that time `rd_data` reads {~value[7], 7'b0}.
- R5: Sector erase is six writes: (A1,0xAA), (A2,0x55), (A1,0x80), (A1,0xAA), (A2,0x55), then (any address in the sector, 0x30). It sets every byte of that sector to 0xFF and leaves every other sector unchanged.
- R6: Chip erase uses the same five writes followed by (A1, 0x10). It sets the whole array to 0xFF and holds `busy` high for exactly ERASE_CYCLES clocks, during which `rd_data` reads 0x00.
- R7: Writes that arrive while `busy` is high are ignored. They neither change the array nor start a command.
- R8: A write that does not match the next expected step of a sequence returns the recogniser to idle, and that write is discarded.
- R9: The lock command is the five erase-prefix writes followed by (A1, 0x40). Once it is set, a program or sector erase that targets the boot sector is dropped, with `busy` staying low. Chip erase then skips the boot sector.
- R10: With `hv_override` high when the command completes, program and sector erase of the boot sector proceed despite the lock.
- R11: `halt` ends any running operation, so `busy` is low on the next clock. While halted, `rd_data` reads 0 and any partial sequence is discarded. Bytes not yet reached by an aborted erase keep their value.
- R12: Only `rst` clears the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high power-on reset |
| wr_en | input | 1 | one-cycle command write strobe |
| wr_addr | input | ADDR_W | command write address |
| wr_data | input | 8 | command write data |
| rd_addr | input | ADDR_W | read address |
| halt | input | 1 | abort and quiet outputs while high |
| hv_override | input | 1 | permits boot-sector program/erase under lock |
| rd_data | output | 8 | read data, polling byte or 0 |
| busy | output | 1 | operation in progress |

## Verification
A wrong recogniser state shows up immediately: a completed sequence would leave `busy` low on the clock after its last write, or an ignored write would raise it. A wrong timer or erase walker shows as a `busy` window that is not exactly PROG_CYCLES or ERASE_CYCLES long, or as bytes that are not 0xFF when the array is swept after the operation. A lost or spurious lock, or a program that sets bits, appears in the first read-back after the command.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

  typedef enum logic [1:0] {
    CMD_PROG   = 2'd0,
    CMD_SERASE = 2'd1,
    CMD_CERASE = 2'd2,
    CMD_LOCK   = 2'd3
  } fcc_cmd_e;

  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_GOT1 = 3'd1,
    SQ_GOT2 = 3'd2,
    SQ_PROG = 3'd3,
    SQ_ERS3 = 3'd4,
    SQ_ERS4 = 3'd5,
    SQ_ERS5 = 3'd6
  } fcc_seq_e;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_PROG  = 2'd1,
    ENG_ERASE = 2'd2
  } fcc_eng_e;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;
  localparam logic [7:0] OP_PROGRAM = 8'hA0;
  localparam logic [7:0] OP_ERASE   = 8'h80;
  localparam logic [7:0] OP_SECTOR  = 8'h30;
  localparam logic [7:0] OP_CHIP    = 8'h10;
  localparam logic [7:0] OP_LOCK    = 8'h40;
  localparam logic [7:0] ERASED     = 8'hFF;

endpackage

// File: rtl/fcc_array.sv
module fcc_array #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        q
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    q <= mem[raddr];
  end
endmodule

// File: rtl/fcc_seq_decode.sv
module fcc_seq_decode import fcc_pkg::*; #(
  parameter int                ADDR_W    = 11,
  parameter logic [ADDR_W-1:0] UNLOCK_A1 = 'h555,
  parameter logic [ADDR_W-1:0] UNLOCK_A2 = 'h2AA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              cmd_valid,
  output fcc_cmd_e          cmd_kind,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [7:0]        cmd_data
);
  fcc_seq_e st, nxt;
  logic     take, at_a1, at_a2;

  assign take  = wr_en && !hold && !flush;
  assign at_a1 = (wr_addr == UNLOCK_A1);
  assign at_a2 = (wr_addr == UNLOCK_A2);

  always_comb begin
    nxt       = st;
    cmd_valid = 1'b0;
    cmd_kind  = CMD_PROG;
    if (take) begin
      case (st)
        SQ_IDLE: nxt = (at_a1 && wr_data == KEY_FIRST)  ? SQ_GOT1 : SQ_IDLE;
        SQ_GOT1: nxt = (at_a2 && wr_data == KEY_SECOND) ? SQ_GOT2 : SQ_IDLE;
        SQ_GOT2: begin
          if (at_a1 && wr_data == OP_PROGRAM)    nxt = SQ_PROG;
          else if (at_a1 && wr_data == OP_ERASE) nxt = SQ_ERS3;
          else                                   nxt = SQ_IDLE;
        end
        SQ_PROG: begin
          nxt       = SQ_IDLE;
          cmd_valid = 1'b1;
          cmd_kind  = CMD_PROG;
        end
        SQ_ERS3: nxt = (at_a1 && wr_data == KEY_FIRST)  ? SQ_ERS4 : SQ_IDLE;
        SQ_ERS4: nxt = (at_a2 && wr_data == KEY_SECOND) ? SQ_ERS5 : SQ_IDLE;
        SQ_ERS5: begin
          nxt = SQ_IDLE;
          if (wr_data == OP_SECTOR) begin
            cmd_valid = 1'b1;
            cmd_kind  = CMD_SERASE;
          end else if (at_a1 && wr_data == OP_CHIP) begin
            cmd_valid = 1'b1;
            cmd_kind  = CMD_CERASE;
          end else if (at_a1 && wr_data == OP_LOCK) begin
            cmd_valid = 1'b1;
            cmd_kind  = CMD_LOCK;
          end
        end
        default: nxt = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) st <= SQ_IDLE;
    else              st <= nxt;
  end

  assign cmd_addr = wr_addr;
  assign cmd_data = wr_data;

  // R7: a busy engine freezes the recogniser
  assert_busy_freezes_seq_R7: assert property (@(posedge clk) disable iff (rst)
    (hold && !flush) |=> $stable(st));
endmodule

// File: rtl/fcc_op_engine.sv
module fcc_op_engine import fcc_pkg::*; #(
  parameter int ADDR_W       = 11,
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 2100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halt,
  input  logic              hv_override,
  input  logic              cmd_valid,
  input  fcc_cmd_e          cmd_kind,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  input  logic [7:0]        ram_q,
  output logic              busy,
  output logic [ADDR_W-1:0] op_addr,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [7:0]        wdata,
  output logic [7:0]        poll_byte
);
  localparam int SIZE = 2 ** ADDR_W;
  localparam int CW   = $clog2(ERASE_CYCLES + 1);
  localparam logic [ADDR_W-1:0] BOOT_LO  = '0;
  localparam logic [ADDR_W-1:0] BOOT_HI  = ADDR_W'(SIZE / 8 - 1);
  localparam logic [ADDR_W-1:0] PARA_LO  = ADDR_W'(SIZE / 8);
  localparam logic [ADDR_W-1:0] PARA_HI  = ADDR_W'(3 * SIZE / 16 - 1);
  localparam logic [ADDR_W-1:0] PARB_LO  = ADDR_W'(3 * SIZE / 16);
  localparam logic [ADDR_W-1:0] PARB_HI  = ADDR_W'(SIZE / 4 - 1);
  localparam logic [ADDR_W-1:0] MAINA_LO = ADDR_W'(SIZE / 4);
  localparam logic [ADDR_W-1:0] MAINA_HI = ADDR_W'(SIZE / 2 - 1);
  localparam logic [ADDR_W-1:0] MAINB_LO = ADDR_W'(SIZE / 2);
  localparam logic [ADDR_W-1:0] TOP      = ADDR_W'(SIZE - 1);

  if (ERASE_CYCLES < SIZE + 1) begin : g_chk_erase
    $error("ERASE_CYCLES must exceed the array size");
  end
  if (PROG_CYCLES < 2 || PROG_CYCLES > ERASE_CYCLES) begin : g_chk_prog
    $error("PROG_CYCLES out of range");
  end

  fcc_eng_e          st;
  logic [CW-1:0]     elap, limit;
  logic [ADDR_W-1:0] op_addr_q, ptr, hi_q;
  logic [7:0]        op_data_q;
  logic              walking, lock_q, ovr_q;

  logic [ADDR_W-1:0] sec_lo, sec_hi;
  logic              in_boot, protect;
  logic              start_prog, start_se, start_ce, start_lock;

  // sector map: boot 1/8, two params 1/16 each, main A 1/4, main B 1/2
  always_comb begin
    if (cmd_addr[ADDR_W-1]) begin
      sec_lo = MAINB_LO; sec_hi = TOP;
    end else if (cmd_addr[ADDR_W-2]) begin
      sec_lo = MAINA_LO; sec_hi = MAINA_HI;
    end else if (cmd_addr[ADDR_W-3]) begin
      if (cmd_addr[ADDR_W-4]) begin
        sec_lo = PARB_LO; sec_hi = PARB_HI;
      end else begin
        sec_lo = PARA_LO; sec_hi = PARA_HI;
      end
    end else begin
      sec_lo = BOOT_LO; sec_hi = BOOT_HI;
    end
  end

  assign in_boot    = (cmd_addr[ADDR_W-1 -: 3] == 3'b000);
  assign protect    = lock_q && !hv_override && in_boot;
  assign start_prog = cmd_valid && cmd_kind == CMD_PROG   && !protect;
  assign start_se   = cmd_valid && cmd_kind == CMD_SERASE && !protect;
  assign start_ce   = cmd_valid && cmd_kind == CMD_CERASE;
  assign start_lock = cmd_valid && cmd_kind == CMD_LOCK;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ENG_IDLE;
      elap      <= '0;
      limit     <= '0;
      op_addr_q <= '0;
      op_data_q <= ERASED;
      ptr       <= '0;
      hi_q      <= '0;
      walking   <= 1'b0;
      ovr_q     <= 1'b0;
    end else if (halt) begin
      st      <= ENG_IDLE;
      elap    <= '0;
      walking <= 1'b0;
    end else begin
      case (st)
        ENG_IDLE: begin
          elap <= '0;
          if (start_prog) begin
            st        <= ENG_PROG;
            limit     <= CW'(PROG_CYCLES);
            op_addr_q <= cmd_addr;
            op_data_q <= cmd_data;
            ovr_q     <= hv_override;
          end else if (start_se || start_ce) begin
            st        <= ENG_ERASE;
            limit     <= CW'(ERASE_CYCLES);
            op_addr_q <= cmd_addr;
            op_data_q <= ERASED;
            ovr_q     <= hv_override;
            walking   <= 1'b1;
            if (start_ce) begin
              ptr  <= lock_q ? PARA_LO : BOOT_LO;
              hi_q <= TOP;
            end else begin
              ptr  <= sec_lo;
              hi_q <= sec_hi;
            end
          end
        end
        default: begin
          elap <= elap + 1'b1;
          if (elap == limit - 1'b1) st <= ENG_IDLE;
          if (walking) begin
            if (ptr == hi_q) walking <= 1'b0;
            else             ptr     <= ptr + 1'b1;
          end
        end
      endcase
    end
  end

  // lock survives halt; only power-on reset clears it
  always_ff @(posedge clk) begin
    if (rst)                                     lock_q <= 1'b0;
    else if (!halt && st == ENG_IDLE && start_lock) lock_q <= 1'b1;
  end

  assign busy      = (st != ENG_IDLE);
  assign op_addr   = op_addr_q;
  assign we        = (st == ENG_PROG && elap == CW'(1)) || (st == ENG_ERASE && walking);
  assign waddr     = (st == ENG_PROG) ? op_addr_q : ptr;
  assign wdata     = (st == ENG_PROG) ? (ram_q & op_data_q) : ERASED;
  assign poll_byte = {~op_data_q[7], 7'b0};

  // R9: no write reaches the boot sector under lock without override
  assert_boot_guarded_R9: assert property (@(posedge clk) disable iff (rst)
    (we && lock_q && !ovr_q) |-> (waddr[ADDR_W-1 -: 3] != 3'b000));

  // R6: the erase walk finishes inside the busy window
  assert_walk_in_window_R6: assert property (@(posedge clk) disable iff (rst)
    (st == ENG_ERASE && walking) |-> (elap < limit));
endmodule

// File: rtl/fcc_flash_ctrl.sv
module fcc_flash_ctrl import fcc_pkg::*; #(
  parameter int                ADDR_W       = 11,
  parameter int                PROG_CYCLES  = 8,
  parameter int                ERASE_CYCLES = 2100,
  parameter logic [ADDR_W-1:0] UNLOCK_A1    = 'h555,
  parameter logic [ADDR_W-1:0] UNLOCK_A2    = 'h2AA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              halt,
  input  logic              hv_override,
  output logic [7:0]        rd_data,
  output logic              busy
);
  logic              cmd_valid;
  fcc_cmd_e          cmd_kind;
  logic [ADDR_W-1:0] cmd_addr, op_addr, waddr, raddr;
  logic [7:0]        cmd_data, ram_q, wdata, poll_byte, poll_q;
  logic              we, show_poll_q, halt_q;

  fcc_seq_decode #(
    .ADDR_W(ADDR_W), .UNLOCK_A1(UNLOCK_A1), .UNLOCK_A2(UNLOCK_A2)
  ) u_decode (
    .clk(clk), .rst(rst), .hold(busy), .flush(halt),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  fcc_op_engine #(
    .ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
  ) u_engine (
    .clk(clk), .rst(rst), .halt(halt), .hv_override(hv_override),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .ram_q(ram_q),
    .busy(busy), .op_addr(op_addr), .we(we), .waddr(waddr),
    .wdata(wdata), .poll_byte(poll_byte)
  );

  // one read port shared: the engine owns it while busy
  assign raddr = busy ? op_addr : rd_addr;

  fcc_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .q(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      show_poll_q <= 1'b0;
      poll_q      <= '0;
      halt_q      <= 1'b0;
    end else begin
      show_poll_q <= busy;
      poll_q      <= poll_byte;
      halt_q      <= halt;
    end
  end

  assign rd_data = halt_q ? 8'h00 : (show_poll_q ? poll_q : ram_q);

  // R4: busy only ever begins right after an accepted command
  assert_busy_from_cmd_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cmd_valid));

  // R11: halt drops busy and quiets the read data on the next clock
  assert_halt_quiets_R11: assert property (@(posedge clk) disable iff (rst)
    halt |=> (!busy && rd_data == 8'h00));
endmodule

// File: tb/test_fcc_flash_ctrl.sv
module test_fcc_flash_ctrl;
  localparam int AW = 11;
  localparam int NB = 2 ** AW;
  localparam int PC = 8;
  localparam int EC = 2100;

  logic          clk = 1'b0, rst = 1'b1, wr_en = 1'b0, halt = 1'b0, hv_override = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0]    wr_data = '0;
  logic [7:0]    rd_data;
  logic          busy;

  int checks = 0, failures = 0;
  logic [7:0] model [NB];
  bit locked = 1'b0;

  always #5 clk = ~clk;

  fcc_flash_ctrl #(.ADDR_W(AW), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) i_fcc_flash_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .halt(halt), .hv_override(hv_override),
    .rd_data(rd_data), .busy(busy)
  );

  function automatic bit f_boot(int a); return a < NB / 8; endfunction
  function automatic int f_lo(int a);
    if (a >= NB / 2) return NB / 2;
    if (a >= NB / 4) return NB / 4;
    if (a >= 3 * NB / 16) return 3 * NB / 16;
    if (a >= NB / 8) return NB / 8;
    return 0;
  endfunction
  function automatic int f_hi(int a);
    if (a >= NB / 2) return NB - 1;
    if (a >= NB / 4) return NB / 2 - 1;
    if (a >= 3 * NB / 16) return NB / 4 - 1;
    if (a >= NB / 8) return 3 * NB / 16 - 1;
    return NB / 8 - 1;
  endfunction
  function automatic int f_poll(int d); return d[7] ? 0 : 128; endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d[7:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic prog_cmd(int a, int d);
    wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'hA0); wr(a, d);
  endtask

  task automatic erase6(int a, int d);
    wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'h80);
    wr('h555, 'hAA); wr('h2AA, 'h55); wr(a, d);
  endtask

  task automatic run_busy(output int n, input int poll_exp, input string tag);
    n = 0;
    while (busy === 1'b1 && n < 3 * EC) begin
      if (n == 1 && poll_exp >= 0) chk(tag, int'(rd_data), poll_exp);
      n++;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic read_byte(int a, output logic [7:0] v);
    @(negedge clk); rd_addr = AW'(a);
    @(negedge clk); v = rd_data;
  endtask

  task automatic verify_all(string tag);
    int mism = 0;
    logic [7:0] v;
    for (int a = 0; a < NB; a++) begin
      read_byte(a, v);
      if (v !== model[a]) mism++;
    end
    chk(tag, mism, 0);
  endtask

  task automatic model_erase(int lo, int hi);
    for (int a = lo; a <= hi; a++) model[a] = 8'hFF;
  endtask

  task automatic model_prog(int a, int d);
    if (!locked || hv_override || !f_boot(a)) model[a] = model[a] & d[7:0];
  endtask

  initial begin
    int n;
    logic [7:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy after reset", int'(busy), 0);

    // chip erase from power-on: whole array to FF
    erase6('h555, 'h10);
    run_busy(n, 0, "R6 poll during chip erase");
    chk("R6 chip erase busy length", n, EC);
    model_erase(0, NB - 1);
    verify_all("R6 array after chip erase");

    // directed program: AND behaviour and poll byte
    prog_cmd('h010, 'hA5);
    run_busy(n, f_poll('hA5), "R4 poll byte A5");
    chk("R4 program busy length", n, PC);
    model_prog('h010, 'hA5);
    read_byte('h010, v); chk("R2 R3 first program", int'(v), 'hA5);
    prog_cmd('h010, 'h3C);
    run_busy(n, f_poll('h3C), "R4 poll byte 3C");
    model_prog('h010, 'h3C);
    read_byte('h010, v); chk("R3 program only clears bits", int'(v), 'h24);

    // random programs
    for (int i = 0; i < 40; i++) begin
      int a, d;
      a = int'($urandom % NB);
      d = int'($urandom % 256);
      prog_cmd(a, d);
      run_busy(n, f_poll(d), "R4 random poll");
      chk("R4 random program busy", n, PC);
      model_prog(a, d);
      read_byte(a, v); chk("R3 random program", int'(v), int'(model[a]));
    end
    verify_all("R2 sweep after random programs");

    // sector erase of param A, others untouched
    erase6('h120, 'h30);
    run_busy(n, 0, "R5 poll during sector erase");
    chk("R5 sector erase busy length", n, EC);
    model_erase(f_lo('h120), f_hi('h120));
    verify_all("R5 only param A erased");

    // writes during busy are ignored
    prog_cmd('h700, 'hF0);
    run_busy(n, -1, "");
    model_prog('h700, 'hF0);
    erase6('h300, 'h30);
    prog_cmd('h700, 'h00);
    run_busy(n, -1, "");
    chk("R7 no queued command after busy", int'(busy), 0);
    model_erase(f_lo('h300), f_hi('h300));
    read_byte('h700, v); chk("R7 program during busy ignored", int'(v), int'(model['h700]));

    // mismatched sequences
    wr('h555, 'hAA); wr('h2AA, 'h55); wr('h2AA, 'hA0); wr('h700, 'h00);
    chk("R8 wrong third address no busy", int'(busy), 0);
    read_byte('h700, v); chk("R8 wrong third address no write", int'(v), int'(model['h700]));
    wr('h555, 'hAA); wr('h555, 'h55); wr('h555, 'hA0); wr('h700, 'h00);
    chk("R8 wrong second address no busy", int'(busy), 0);
    read_byte('h700, v); chk("R8 wrong second address no write", int'(v), int'(model['h700]));

    // lock: boot protected, chip erase skips boot
    prog_cmd('h020, 'h5A); run_busy(n, -1, ""); model_prog('h020, 'h5A);
    erase6('h555, 'h40);
    chk("R9 lock command no busy", int'(busy), 0);
    locked = 1'b1;
    prog_cmd('h020, 'h00);
    chk("R9 boot program dropped busy", int'(busy), 0);
    read_byte('h020, v); chk("R9 boot program dropped data", int'(v), 'h5A);
    erase6('h050, 'h30);
    chk("R9 boot sector erase dropped busy", int'(busy), 0);
    read_byte('h020, v); chk("R9 boot sector erase dropped data", int'(v), 'h5A);
    erase6('h555, 'h10);
    run_busy(n, -1, "");
    chk("R9 locked chip erase busy length", n, EC);
    model_erase(NB / 8, NB - 1);
    verify_all("R9 chip erase keeps boot");

    // high-voltage override
    hv_override = 1'b1;
    prog_cmd('h020, 'h0F);
    run_busy(n, -1, "");
    chk("R10 override program busy", n, PC);
    model_prog('h020, 'h0F);
    read_byte('h020, v); chk("R10 override program data", int'(v), 'h0A);
    erase6('h0C0, 'h30);
    run_busy(n, -1, "");
    chk("R10 override sector erase busy", n, EC);
    model_erase(0, NB / 8 - 1);
    hv_override = 1'b0;
    verify_all("R10 boot erased under override");

    // halt aborts a chip erase
    prog_cmd(NB - 1, 'h12); run_busy(n, -1, ""); model_prog(NB - 1, 'h12);
    erase6('h555, 'h10);
    repeat (10) @(negedge clk);
    halt = 1'b1;
    @(negedge clk);
    chk("R11 busy low after halt", int'(busy), 0);
    chk("R11 read data quiet in halt", int'(rd_data), 0);
    @(negedge clk);
    halt = 1'b0;
    repeat (2) @(negedge clk);
    read_byte(NB - 1, v); chk("R11 unreached byte kept", int'(v), 'h12);
    // halt discards a partial sequence
    wr('h555, 'hAA); wr('h2AA, 'h55);
    @(negedge clk); halt = 1'b1; @(negedge clk); halt = 1'b0;
    wr('h555, 'hA0); wr(NB - 1, 'h00);
    chk("R11 partial sequence discarded busy", int'(busy), 0);
    read_byte(NB - 1, v); chk("R11 partial sequence discarded data", int'(v), 'h12);
    erase6('h555, 'h10);
    run_busy(n, -1, "");
    model_erase(NB / 8, NB - 1);
    verify_all("R11 resync after abort");

    // reset clears lock
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    locked = 1'b0;
    chk("R1 busy after second reset", int'(busy), 0);
    prog_cmd('h030, 'h00);
    run_busy(n, -1, "");
    chk("R12 boot program after reset runs", n, PC);
    read_byte('h030, v); chk("R12 boot program after reset data", int'(v), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule